// File: doc/BRIEF.md
# Biphase Infrared Frame Transmitter

This block turns a latched system code and command code into repeating infrared frames. A key scanner tells it when a key is held (`code_valid`) and when the key is let go (`key_release`). The block then serializes a fixed frame with biphase (Manchester) coding. The frame holds two start bits, a toggle bit, then the system field and then the command field. Frames repeat on a fixed slot of 64 bit-times until a release is seen. All timing advances only on cycles where the oscillator tick `clk_en` is high.

Two outputs are produced, and each has its own output enable. The baseband code drives a decoder or a test fixture. The carrier-modulated code drives the infrared emitter stage. The carrier is the tick rate divided by 12, high for 3 ticks out of 12. While no frame is in progress, both enables are low, which means both pins float. A two-bit mode input does three jobs. It can clear the block. It can select normal timing of 768 ticks per bit. It can select either of two fast test timings of 4 ticks per bit, which keep simulation short.

Top module: `ir_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `code_oe` and `mcode_oe` are 0 and `code_out` and `mcode_out` are 0.
- R2: A frame starts on a tick (`clk_en`=1) where the block is idle, `code_valid`=1 and `mode_sel`!=11. The frame bits, in the order sent, are: 1, 1, the toggle bit, the system code MSB first, and then the command code MSB first.
- R3: Each bit is biphase coded. A 1 is sent low for the first half of the bit period and high for the second half. A 0 is sent high for the first half and low for the second half.
- R4: The bit period is 768 ticks when `mode_sel`=00 and 4 ticks when `mode_sel` is 10 or 01. The half-bit boundary lies at half the period.
- R5: One repetition slot lasts 64 bit-times. The 14 frame bits come first, and `code_out` stays 0 with the enables high for the rest of the slot. A new identical frame follows at once while no release has been seen.
- R6: When `key_release` is seen on a tick during a frame, the current slot completes. The enables then drop on the tick that ends the slot, and the toggle bit is inverted for the next key press.
- R7: `mcode_out` equals `code_out` AND a carrier. The carrier is high for the first 3 of every 12 ticks, and its count restarts at the first tick of every frame.
- R8: `mode_sel`=11 makes the block idle at the next clock edge and clears the toggle bit to 0.
- R9: On cycles with `clk_en`=0, no timing advances and no frame starts.
- R10: The system and command codes are captured when a frame starts. Later changes on `sys_code` and `cmd_code` do not alter frames that are already repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Oscillator tick; all timing advances only when high |
| code_valid | input | 1 | Key held with legal codes; starts a frame from idle |
| key_release | input | 1 | Key let go; ends transmission at the slot end |
| sys_code | input | 5 | System code to send |
| cmd_code | input | 6 | Command code to send |
| mode_sel | input | 2 | 00 normal, 10 / 01 fast test timing, 11 clear |
| code_out | output | 1 | Baseband biphase code |
| code_oe | output | 1 | Output enable for `code_out` |
| mcode_out | output | 1 | Carrier-modulated code |
| mcode_oe | output | 1 | Output enable for `mcode_out` |

## Verification
The bench compares every output cycle against a model built on the tick count. That model would catch three faults:
- Half-bits swapped in the biphase coding.
- Fields sent LSB first.
- The carrier not restarting at the frame boundary. In fast mode, 256 ticks is not a multiple of 12, so a missed restart shows as a phase slip in the second frame.

Several edge cases are targeted:
- A release placed in the middle of the second slot. A design that stops at once, or that runs into a third slot, fails the enable check at the exact slot end.
- The toggle bit, checked on the next press and again after a clear.
- Ticks withheld in the middle of a frame. A design that counts raw clocks drifts away from the model.
- Changes to the input codes after the start, which a design that re-samples the inputs would send.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_FAST_B = 2'b01,
    MODE_FAST_A = 2'b10,
    MODE_CLEAR  = 2'b11
  } tx_mode_e;

  // fast timing is used by both test selections
  function automatic logic mode_is_fast(input logic [1:0] m);
    return (m == MODE_FAST_A) || (m == MODE_FAST_B);
  endfunction

  function automatic logic mode_is_clear(input logic [1:0] m);
    return m == MODE_CLEAR;
  endfunction

  // biphase line level: a one is low then high, a zero high then low
  function automatic logic biphase_level(input logic data, input logic late_half);
    return late_half ? data : ~data;
  endfunction

endpackage

// File: rtl/ir_bit_timer.sv
module ir_bit_timer #(
  parameter int BIT_TICKS  = 768,
  parameter int FAST_TICKS = 4,
  parameter int SLOT_BITS  = 64,
  localparam int TICK_W = $clog2(BIT_TICKS),
  localparam int IDX_W  = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              tick,
  input  logic              fast,
  output logic [TICK_W-1:0] tick_cnt,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              late_half,
  output logic              bit_end,
  output logic              slot_end
);

  localparam logic [TICK_W-1:0] LIM_RUN   = TICK_W'(BIT_TICKS - 1);
  localparam logic [TICK_W-1:0] LIM_FAST  = TICK_W'(FAST_TICKS - 1);
  localparam logic [TICK_W-1:0] HALF_RUN  = TICK_W'(BIT_TICKS / 2);
  localparam logic [TICK_W-1:0] HALF_FAST = TICK_W'(FAST_TICKS / 2);
  localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(SLOT_BITS - 1);

  logic [TICK_W-1:0] lim;
  logic [TICK_W-1:0] half;

  assign lim       = fast ? LIM_FAST : LIM_RUN;
  assign half      = fast ? HALF_FAST : HALF_RUN;
  assign late_half = tick_cnt >= half;
  // >= rather than == so a switch to fast timing mid-bit still ends the bit
  assign bit_end   = run && tick && (tick_cnt >= lim);
  assign slot_end  = bit_end && (bit_idx == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (clear || !run) begin
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (tick) begin
      if (bit_end) begin
        tick_cnt <= '0;
        bit_idx  <= slot_end ? '0 : bit_idx + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ir_carrier.sv
module ir_carrier #(
  parameter int DIV  = 12,
  parameter int HIGH = 3,
  localparam int CW  = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic car_on
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] ONS  = CW'(HIGH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !run || (tick && restart)) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign car_on = run && (cnt < ONS);

endmodule

// File: rtl/ir_frame_ctrl.sv
module ir_frame_ctrl #(
  parameter int SYS_W = 5,
  parameter int CMD_W = 6,
  localparam int FRAME_BITS = 3 + SYS_W + CMD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  tick,
  input  logic                  code_valid,
  input  logic                  key_release,
  input  logic [SYS_W-1:0]      sys_in,
  input  logic [CMD_W-1:0]      cmd_in,
  input  logic                  slot_end,
  output logic                  busy,
  output logic                  rel_pend,
  output logic [FRAME_BITS-1:0] frame_word
);

  logic             toggle;
  logic [SYS_W-1:0] sys_q;
  logic [CMD_W-1:0] cmd_q;
  logic             start_evt;
  logic             rel_evt;
  logic             stop_evt;

  assign start_evt = tick && !busy && code_valid && !clear;
  assign rel_evt   = tick && busy && key_release;
  assign stop_evt  = busy && slot_end && (rel_pend || rel_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      toggle   <= 1'b0;
      rel_pend <= 1'b0;
      sys_q    <= '0;
      cmd_q    <= '0;
    end else if (clear) begin
      busy     <= 1'b0;
      toggle   <= 1'b0;
      rel_pend <= 1'b0;
    end else if (start_evt) begin
      busy  <= 1'b1;
      sys_q <= sys_in;
      cmd_q <= cmd_in;
    end else if (stop_evt) begin
      busy     <= 1'b0;
      rel_pend <= 1'b0;
      toggle   <= ~toggle;
    end else if (rel_evt) begin
      rel_pend <= 1'b1;
    end
  end

  // sent MSB first: two start ones, toggle, system, command
  assign frame_word = {2'b11, toggle, sys_q, cmd_q};

endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx #(
  parameter int BIT_TICKS  = 768,
  parameter int FAST_TICKS = 4,
  parameter int SLOT_BITS  = 64,
  parameter int SYS_W      = 5,
  parameter int CMD_W      = 6,
  parameter int CAR_DIV    = 12,
  parameter int CAR_HIGH   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             code_valid,
  input  logic             key_release,
  input  logic [SYS_W-1:0] sys_code,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [1:0]       mode_sel,
  output logic             code_out,
  output logic             code_oe,
  output logic             mcode_out,
  output logic             mcode_oe
);
  import ir_tx_pkg::*;

  localparam int FRAME_BITS = 3 + SYS_W + CMD_W;
  localparam int TICK_W     = $clog2(BIT_TICKS);
  localparam int IDX_W      = $clog2(SLOT_BITS);

  logic                  clear;
  logic                  fast;
  logic                  busy;
  logic                  rel_pend;
  logic [FRAME_BITS-1:0] frame_word;
  logic [FRAME_BITS-1:0] shifted;
  logic [TICK_W-1:0]     tick_cnt;
  logic [IDX_W-1:0]      bit_idx;
  logic                  late_half;
  logic                  bit_end;
  logic                  slot_end;
  logic                  car_on;
  logic                  in_frame;
  logic                  cur_bit;

  assign clear = mode_is_clear(mode_sel);
  assign fast  = mode_is_fast(mode_sel);

  ir_frame_ctrl #(.SYS_W(SYS_W), .CMD_W(CMD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .tick       (clk_en),
    .code_valid (code_valid),
    .key_release(key_release),
    .sys_in     (sys_code),
    .cmd_in     (cmd_code),
    .slot_end   (slot_end),
    .busy       (busy),
    .rel_pend   (rel_pend),
    .frame_word (frame_word)
  );

  ir_bit_timer #(.BIT_TICKS(BIT_TICKS), .FAST_TICKS(FAST_TICKS), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .run      (busy),
    .tick     (clk_en),
    .fast     (fast),
    .tick_cnt (tick_cnt),
    .bit_idx  (bit_idx),
    .late_half(late_half),
    .bit_end  (bit_end),
    .slot_end (slot_end)
  );

  ir_carrier #(.DIV(CAR_DIV), .HIGH(CAR_HIGH)) u_car (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .run    (busy),
    .tick   (clk_en),
    .restart(slot_end),
    .car_on (car_on)
  );

  assign shifted   = frame_word << bit_idx;
  assign cur_bit   = shifted[FRAME_BITS-1];
  assign in_frame  = bit_idx < IDX_W'(FRAME_BITS);

  assign code_out  = busy && in_frame && biphase_level(cur_bit, late_half);
  assign mcode_out = code_out && car_on;
  assign code_oe   = busy;
  assign mcode_oe  = busy;

endmodule

// File: rtl/ir_frame_tx_chk.sv
module ir_frame_tx_chk #(
  parameter int BIT_TICKS  = 768,
  parameter int FRAME_BITS = 14,
  parameter int TICK_W     = 10,
  parameter int IDX_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              code_valid,
  input logic [1:0]        mode_sel,
  input logic              code_out,
  input logic              code_oe,
  input logic              mcode_out,
  input logic              mcode_oe,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              slot_end,
  input logic              rel_pend
);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !code_oe |-> (!code_out && !mcode_out));

  p_oe_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    code_oe == mcode_oe);

  // a fresh frame opens with the low half of a start one
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_oe && clk_en && code_valid && mode_sel != 2'b11) |=> (code_oe && !code_out));

  p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt < TICK_W'(BIT_TICKS));

  p_gap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_oe && bit_idx >= IDX_W'(FRAME_BITS)) |-> !code_out);

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && rel_pend && mode_sel != 2'b11) |=> !code_oe);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mcode_out |-> code_out);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> !code_oe);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && mode_sel != 2'b11) |=> ($stable(tick_cnt) && $stable(bit_idx) && $stable(code_oe)));

endmodule

bind ir_frame_tx ir_frame_tx_chk #(
  .BIT_TICKS (BIT_TICKS),
  .FRAME_BITS(FRAME_BITS),
  .TICK_W    (TICK_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .code_valid(code_valid),
  .mode_sel  (mode_sel),
  .code_out  (code_out),
  .code_oe   (code_oe),
  .mcode_out (mcode_out),
  .mcode_oe  (mcode_oe),
  .tick_cnt  (tick_cnt),
  .bit_idx   (bit_idx),
  .slot_end  (slot_end),
  .rel_pend  (rel_pend)
);

// File: tb/test_ir_frame_tx.sv
`timescale 1ns/1ps
module test_ir_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       code_valid = 1'b0;
  logic       key_release = 1'b0;
  logic [4:0] sys_code = '0;
  logic [5:0] cmd_code = '0;
  logic [1:0] mode_sel = 2'b00;
  logic       code_out, code_oe, mcode_out, mcode_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ir_frame_tx i_ir_frame_tx (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .code_valid(code_valid),
    .key_release(key_release), .sys_code(sys_code), .cmd_code(cmd_code),
    .mode_sel(mode_sel), .code_out(code_out), .code_oe(code_oe),
    .mcode_out(mcode_out), .mcode_oe(mcode_oe)
  );

  // expected {code, mcode} n ticks after the start tick
  function automatic logic [1:0] model(input int n, input int p, input logic [4:0] s,
                                       input logic [5:0] c, input logic tg);
    int per = 64 * p;
    int r = n % per;
    int b = r / p;
    int t = r % p;
    logic [13:0] w = {2'b11, tg, s, c};
    logic code = 1'b0;
    if (b < 14) code = (t < p / 2) ? !w[13 - b] : w[13 - b];
    return {code, code && ((r % 12) < 3)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!code_oe && !mcode_oe, "R1 enables low after reset", {code_oe, mcode_oe}, 0);
    check(!code_out && !mcode_out, "R1 outputs low after reset", {code_out, mcode_out}, 0);
  endtask

  task automatic t_no_tick_start;
    @(negedge clk);
    clk_en = 1'b0; code_valid = 1'b1; mode_sel = 2'b10;
    repeat (5) @(negedge clk);
    check(!code_oe, "R9 no start without tick", code_oe, 0);
    code_valid = 1'b0;
  endtask

  task automatic t_stream(input logic [1:0] md, input logic [4:0] s, input logic [5:0] c,
                          input logic tg, input int ncyc, input bit stall,
                          input int rel_at, input string tag);
    int p = (md == 2'b00) ? 768 : 4;
    int per = 64 * p;
    int n = 0;
    int end_n = (rel_at >= 0) ? (rel_at / per + 1) * per : -1;
    bit bad_oe = 0;
    bit bad_dat = 0;
    @(negedge clk);
    mode_sel = md; sys_code = s; cmd_code = c; code_valid = 1'b1; clk_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      logic exoe;
      logic [1:0] ex;
      bit en;
      @(negedge clk);
      if (i == 0) begin
        code_valid = 1'b0; sys_code = ~s; cmd_code = ~c;
      end
      key_release = 1'b0;
      exoe = !(end_n >= 0 && n >= end_n);
      ex = exoe ? model(n, p, s, c, tg) : 2'b00;
      if (!bad_oe && ({code_oe, mcode_oe} != {exoe, exoe})) begin
        bad_oe = 1;
        $display("FAIL %s enables at tick %0d actual=%0h expected=%0h",
                 tag, n, {code_oe, mcode_oe}, {exoe, exoe});
      end
      if (!bad_dat && ({code_out, mcode_out} != ex)) begin
        bad_dat = 1;
        $display("FAIL %s data at tick %0d actual=%0h expected=%0h",
                 tag, n, {code_out, mcode_out}, ex);
      end
      en = stall ? ((i % 5) != 2) : 1'b1;
      if (rel_at >= 0 && n == rel_at) begin
        en = 1'b1; key_release = 1'b1;
      end
      clk_en = en;
      if (en) n++;
    end
    checks += 2;
    if (bad_oe) fails++;
    if (bad_dat) fails++;
    clk_en = 1'b1;
    key_release = 1'b0;
  endtask

  task automatic t_clear(input string tag);
    @(negedge clk);
    mode_sel = 2'b11;
    @(negedge clk);
    check(!code_oe && !code_out && !mcode_out, tag, {code_oe, code_out, mcode_out}, 0);
    mode_sel = 2'b00;
  endtask

  task automatic t_async_reset;
    t_stream(2'b10, 5'h05, 6'h11, 1'b0, 40, 0, -1, "R2 R3 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!code_oe && !code_out && !mcode_oe, "R1 idle after mid-frame reset",
          {code_oe, code_out, mcode_oe}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_tick_start();
    // fast mode, two slots, release in the second slot; codes scrambled after start
    t_stream(2'b10, 5'h15, 6'h2A, 1'b0, 520, 0, 300, "R2 R3 R4 R5 R6 R7 R10 fast A");
    // toggle inverted on the next press; ticks withheld on some cycles
    t_stream(2'b01, 5'h0B, 6'h33, 1'b1, 600, 1, -1, "R6 R9 R4 fast B with stalls");
    t_clear("R8 clear stops frame");
    // toggle back to 0 after clear
    t_stream(2'b10, 5'h1F, 6'h00, 1'b0, 300, 0, -1, "R8 toggle cleared");
    t_clear("R8 clear second");
    // normal timing: 768-tick bits, repeat across the slot boundary
    t_stream(2'b00, 5'h01, 6'h3E, 1'b0, 50000, 0, -1, "R3 R4 R5 R7 normal timing");
    t_clear("R8 clear normal");
    t_async_reset();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule